// File: doc/BRIEF.md
# Hardware Cursor Overlay Inserter

This block merges a small pointer image into a live RGB pixel stream. A 32 by 32 pixel image with two bits per pixel sits in an internal byte-wide memory, which the host loads through a simple write port. Each two-bit code picks one of four treatments for the video pixel under it: show one of two solid colours, leave the video alone, or apply a special treatment. A mode input selects the special treatment. It either inverts the video pixel or replaces it with a third colour.

The pointer is placed by two coordinate pairs. The first names the "tip" pixel inside the image. The second gives the screen coordinate where that tip lands, counted in input pixels from the upper-left corner. The image therefore starts at screen position minus tip offset. When the tip sits near the left or top screen border, the image is cut off there. At the right and bottom borders, the image simply runs beyond the last pixel of the frame.

The pixel stream carries a valid strobe plus line-start and frame-start markers. The output stream has the same timing, delayed by one clock, so the image lookup lines up with its pixel.

Top module: `cursor_overlay`

## Requirements
- R1: Image byte k holds row k/8, columns 4*(k%8) to 4*(k%8)+3. The leftmost of these four columns is in bits 1:0, the next in bits 3:2, then bits 5:4, and the rightmost in bits 7:6.
- R2: Code 00 under an active cursor pixel outputs `color_b`.
- R3: Code 01 under an active cursor pixel outputs `color_a`.
- R4: Code 10 outputs the input pixel unchanged.
- R5: Code 11 with `cursor_mode` = 0 outputs the bitwise complement of the input pixel.
- R6: Code 11 with `cursor_mode` = 1 outputs `color_aux`.
- R7: A screen pixel (x, y) lies under image column x - tip_col_pos + tip_col and row y - tip_row_pos + tip_row when both values are in 0..31. When tip_col_pos < tip_col or tip_row_pos < tip_row, the leading image columns or rows fall off screen and are not shown.
- R8: Pixels outside the image window pass through unchanged. Image parts past the right or bottom frame edge produce no extra output.
- R9: `out_valid`, `out_sol` and `out_sof` equal `in_valid`, `in_sol` and `in_sof` of one clock earlier. Cycles with `in_valid` = 0 do not advance the pixel position.
- R10: With `cursor_en` = 0 at the input cycle, the output pixel equals the input pixel.
- R11: A valid pixel with `in_sof` = 1 is at (0,0). A valid pixel with only `in_sol` = 1 is at column 0 of the next row. Every other valid pixel is one column to the right of the previous valid pixel.
- R12: While reset is asserted and in the first cycle after it, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| img_we | input | 1 | Image memory write strobe |
| img_waddr | input | 8 | Image byte address |
| img_wdata | input | 8 | Image byte data |
| cursor_en | input | 1 | Global cursor enable |
| cursor_mode | input | 1 | Code 11 treatment: 0 invert, 1 third colour |
| tip_col | input | 5 | Tip column inside the image |
| tip_row | input | 5 | Tip row inside the image |
| tip_col_pos | input | 12 | Screen column of the tip |
| tip_row_pos | input | 12 | Screen row of the tip |
| color_a | input | 24 | Colour for code 01 |
| color_b | input | 24 | Colour for code 00 |
| color_aux | input | 24 | Colour for code 11 in mode 1 |
| in_valid | input | 1 | Input pixel valid |
| in_sol | input | 1 | Input line start |
| in_sof | input | 1 | Input frame start |
| in_pix | input | 24 | Input RGB pixel |
| out_valid | output | 1 | Output pixel valid |
| out_sol | output | 1 | Output line start |
| out_sof | output | 1 | Output frame start |
| out_pix | output | 24 | Output RGB pixel |

## Verification
Every output is due exactly one clock after the pixel that produced it. The valid, line-start and frame-start markers and the merged pixel all appear in that same cycle. The bench drives each input on a falling edge. On the next falling edge it compares the outputs with an expectation held over from the previous step, so each check lands in the cycle in which its register has just been loaded. The mode and colour inputs are read at output time. For that reason, the bench inserts one idle step after every frame before it changes the configuration.

// File: rtl/cursor_ovl_pkg.sv
package cursor_ovl_pkg;

   // two-bit image codes
   typedef enum logic [1:0] {
      PAT_COLOR_B = 2'b00,
      PAT_COLOR_A = 2'b01,
      PAT_CLEAR   = 2'b10,
      PAT_SPECIAL = 2'b11
   } pat_code_e;

endpackage

// File: rtl/cursor_image_ram.sv
module cursor_image_ram #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);

   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_aw
      $error("cursor_image_ram: ADDR_W out of range");
   end

   logic [DATA_W-1:0] mem [DEPTH];

   // read returns the previous contents on a same-address write
   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
      rdata <= mem[raddr];
   end

endmodule

// File: rtl/cursor_locator.sv
module cursor_locator #(
   parameter int COORD_W  = 12,
   parameter int CUR_LOG2 = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic                in_sol,
   input  logic                in_sof,
   input  logic                cursor_en,
   input  logic [CUR_LOG2-1:0] tip_col,
   input  logic [CUR_LOG2-1:0] tip_row,
   input  logic [COORD_W-1:0]  tip_col_pos,
   input  logic [COORD_W-1:0]  tip_row_pos,
   output logic                hit,
   output logic [CUR_LOG2-1:0] img_col,
   output logic [CUR_LOG2-1:0] img_row
);

   localparam int DW = COORD_W + 2;

   logic [COORD_W-1:0] last_x, last_y, cur_x, cur_y;
   logic [DW-1:0]      dx, dy;
   logic               in_x, in_y;

   // position of the pixel now at the input
   always_comb begin
      cur_x = (in_sol || in_sof) ? '0 : last_x + 1'b1;
      if (in_sof)      cur_y = '0;
      else if (in_sol) cur_y = last_y + 1'b1;
      else             cur_y = last_y;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_x <= '0;
         last_y <= '0;
      end else if (in_valid) begin
         last_x <= cur_x;
         last_y <= cur_y;
      end
   end

   // offset into the image; negative or large values fall out of the window
   always_comb begin
      dx   = DW'(cur_x) + DW'(tip_col) - DW'(tip_col_pos);
      dy   = DW'(cur_y) + DW'(tip_row) - DW'(tip_row_pos);
      in_x = (dx >> CUR_LOG2) == '0;
      in_y = (dy >> CUR_LOG2) == '0;
   end

   assign hit     = cursor_en && in_valid && in_x && in_y;
   assign img_col = dx[CUR_LOG2-1:0];
   assign img_row = dy[CUR_LOG2-1:0];

endmodule

// File: rtl/cursor_pattern_mux.sv
module cursor_pattern_mux
   import cursor_ovl_pkg::*;
#(
   parameter int CH_W   = 8,
   parameter int NUM_CH = 3,
   localparam int PIX_W = CH_W * NUM_CH
) (
   input  logic             active,
   input  logic [1:0]       code,
   input  logic             mode,
   input  logic [PIX_W-1:0] pix_in,
   input  logic [PIX_W-1:0] color_a,
   input  logic [PIX_W-1:0] color_b,
   input  logic [PIX_W-1:0] color_aux,
   output logic [PIX_W-1:0] pix_out
);

   logic [PIX_W-1:0] inv_pix;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      assign inv_pix[c*CH_W +: CH_W] = ~pix_in[c*CH_W +: CH_W];
   end

   always_comb begin
      pix_out = pix_in;
      if (active) begin
         unique case (pat_code_e'(code))
            PAT_COLOR_B: pix_out = color_b;
            PAT_COLOR_A: pix_out = color_a;
            PAT_CLEAR:   pix_out = pix_in;
            PAT_SPECIAL: pix_out = mode ? color_aux : inv_pix;
            default:     pix_out = pix_in;
         endcase
      end
   end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay #(
   parameter int COORD_W  = 12,
   parameter int CUR_LOG2 = 5,
   parameter int CH_W     = 8,
   parameter int NUM_CH   = 3,
   localparam int PIX_W   = CH_W * NUM_CH,
   localparam int IMG_AW  = 2 * CUR_LOG2 - 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                img_we,
   input  logic [IMG_AW-1:0]   img_waddr,
   input  logic [7:0]          img_wdata,
   input  logic                cursor_en,
   input  logic                cursor_mode,
   input  logic [CUR_LOG2-1:0] tip_col,
   input  logic [CUR_LOG2-1:0] tip_row,
   input  logic [COORD_W-1:0]  tip_col_pos,
   input  logic [COORD_W-1:0]  tip_row_pos,
   input  logic [PIX_W-1:0]    color_a,
   input  logic [PIX_W-1:0]    color_b,
   input  logic [PIX_W-1:0]    color_aux,
   input  logic                in_valid,
   input  logic                in_sol,
   input  logic                in_sof,
   input  logic [PIX_W-1:0]    in_pix,
   output logic                out_valid,
   output logic                out_sol,
   output logic                out_sof,
   output logic [PIX_W-1:0]    out_pix
);

   if (CUR_LOG2 < 2 || CUR_LOG2 > 6) begin : g_bad_size
      $error("cursor_overlay: CUR_LOG2 must be 2..6");
   end
   if (COORD_W <= CUR_LOG2) begin : g_bad_coord
      $error("cursor_overlay: COORD_W too small");
   end

   logic                hit;
   logic [CUR_LOG2-1:0] img_col, img_row;
   logic [IMG_AW-1:0]   raddr;
   logic [7:0]          rdata;

   logic                v_q, sol_q, sof_q, hit_q;
   logic [1:0]          sel_q, code_q;
   logic [PIX_W-1:0]    pix_q;

   cursor_locator #(
      .COORD_W (COORD_W),
      .CUR_LOG2(CUR_LOG2)
   ) u_loc (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_sol     (in_sol),
      .in_sof     (in_sof),
      .cursor_en  (cursor_en),
      .tip_col    (tip_col),
      .tip_row    (tip_row),
      .tip_col_pos(tip_col_pos),
      .tip_row_pos(tip_row_pos),
      .hit        (hit),
      .img_col    (img_col),
      .img_row    (img_row)
   );

   // row-major: row then the group of four columns
   assign raddr = {img_row, img_col[CUR_LOG2-1:2]};

   cursor_image_ram #(
      .ADDR_W(IMG_AW),
      .DATA_W(8)
   ) u_ram (
      .clk  (clk),
      .we   (img_we),
      .waddr(img_waddr),
      .wdata(img_wdata),
      .raddr(raddr),
      .rdata(rdata)
   );

   // video delay matching the memory read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q   <= 1'b0;
         sol_q <= 1'b0;
         sof_q <= 1'b0;
         hit_q <= 1'b0;
         sel_q <= '0;
         pix_q <= '0;
      end else begin
         v_q   <= in_valid;
         sol_q <= in_sol;
         sof_q <= in_sof;
         hit_q <= hit;
         sel_q <= img_col[1:0];
         pix_q <= in_pix;
      end
   end

   assign code_q = rdata[{sel_q, 1'b0} +: 2];

   cursor_pattern_mux #(
      .CH_W  (CH_W),
      .NUM_CH(NUM_CH)
   ) u_mux (
      .active   (hit_q),
      .code     (code_q),
      .mode     (cursor_mode),
      .pix_in   (pix_q),
      .color_a  (color_a),
      .color_b  (color_b),
      .color_aux(color_aux),
      .pix_out  (out_pix)
   );

   assign out_valid = v_q;
   assign out_sol   = sol_q;
   assign out_sof   = sof_q;

endmodule

// File: rtl/cursor_overlay_chk.sv
module cursor_overlay_chk #(
   parameter int PIX_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_sol,
   input logic [PIX_W-1:0] in_pix,
   input logic             cursor_en,
   input logic             cursor_mode,
   input logic [PIX_W-1:0] color_a,
   input logic [PIX_W-1:0] color_b,
   input logic [PIX_W-1:0] color_aux,
   input logic             out_valid,
   input logic             out_sol,
   input logic [PIX_W-1:0] out_pix,
   input logic             hit_q,
   input logic [1:0]       code_q,
   input logic [PIX_W-1:0] pix_q
);

   assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_idle_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_sol_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_sol |=> out_sol);

   assert_disabled_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !cursor_en |=> (out_pix == $past(in_pix)));

   assert_color_b_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_q && code_q == 2'b00) |-> (out_pix == color_b));

   assert_color_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_q && code_q == 2'b01) |-> (out_pix == color_a));

   assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_q && code_q == 2'b10) |-> (out_pix == pix_q));

   assert_invert_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_q && code_q == 2'b11 && !cursor_mode) |-> (out_pix == ~pix_q));

   assert_aux_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_q && code_q == 2'b11 && cursor_mode) |-> (out_pix == color_aux));

   assert_outside_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_q |-> (out_pix == pix_q));

endmodule

bind cursor_overlay cursor_overlay_chk #(.PIX_W(PIX_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .in_sol     (in_sol),
   .in_pix     (in_pix),
   .cursor_en  (cursor_en),
   .cursor_mode(cursor_mode),
   .color_a    (color_a),
   .color_b    (color_b),
   .color_aux  (color_aux),
   .out_valid  (out_valid),
   .out_sol    (out_sol),
   .out_pix    (out_pix),
   .hit_q      (hit_q),
   .code_q     (code_q),
   .pix_q      (pix_q)
);

// File: tb/cursor_overlay_tb.sv
`timescale 1ns/1ps
module cursor_overlay_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        img_we = 1'b0;
   logic [7:0]  img_waddr = '0;
   logic [7:0]  img_wdata = '0;
   logic        cursor_en = 1'b0;
   logic        cursor_mode = 1'b0;
   logic [4:0]  tip_col = '0, tip_row = '0;
   logic [11:0] tip_col_pos = '0, tip_row_pos = '0;
   logic [23:0] color_a = 24'h12_34_56, color_b = 24'hA0_B0_C0, color_aux = 24'h0F_F0_5A;
   logic        in_valid = 1'b0, in_sol = 1'b0, in_sof = 1'b0;
   logic [23:0] in_pix = '0;
   logic        out_valid, out_sol, out_sof;
   logic [23:0] out_pix;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   logic [7:0] img [256];

   // expectation carried to the next falling edge
   bit          pend_have = 0;
   logic        pend_v, pend_sol, pend_sof;
   logic [23:0] pend_pix;
   string       pend_tag;

   always #4 clk = ~clk;   // 125 MHz

   cursor_overlay u_dut (
      .clk(clk), .rst_n(rst_n),
      .img_we(img_we), .img_waddr(img_waddr), .img_wdata(img_wdata),
      .cursor_en(cursor_en), .cursor_mode(cursor_mode),
      .tip_col(tip_col), .tip_row(tip_row),
      .tip_col_pos(tip_col_pos), .tip_row_pos(tip_row_pos),
      .color_a(color_a), .color_b(color_b), .color_aux(color_aux),
      .in_valid(in_valid), .in_sol(in_sol), .in_sof(in_sof), .in_pix(in_pix),
      .out_valid(out_valid), .out_sol(out_sol), .out_sof(out_sof), .out_pix(out_pix)
   );

   task automatic check_pending();
      if (!pend_have) return;
      n_cmp++;
      if (out_valid !== pend_v) begin
         n_bad++;
         $display("FAIL R9 out_valid actual=%0b expected=%0b", out_valid, pend_v);
      end else if (pend_v && (out_sol !== pend_sol || out_sof !== pend_sof)) begin
         n_bad++;
         $display("FAIL R9 markers actual=%0b%0b expected=%0b%0b",
                  out_sol, out_sof, pend_sol, pend_sof);
      end else if (pend_v && out_pix !== pend_pix) begin
         n_bad++;
         $display("FAIL %s out_pix actual=%06h expected=%06h", pend_tag, out_pix, pend_pix);
      end
   endtask

   // model of R1, R7, R11 placement and R2..R6, R8, R10 treatments
   function automatic logic [23:0] model(int x, int y, logic [23:0] p, output string tag);
      int dx = x + int'(tip_col) - int'(tip_col_pos);
      int dy = y + int'(tip_row) - int'(tip_row_pos);
      int code;
      if (!cursor_en) begin tag = "R10"; return p; end
      if (dx < 0 || dx > 31 || dy < 0 || dy > 31) begin
         tag = (tip_col_pos < 12'(tip_col) || tip_row_pos < 12'(tip_row)) ? "R7" : "R8";
         return p;
      end
      code = (img[dy*8 + dx/4] >> (2*(dx%4))) & 3;   // R1 layout
      case (code)
         0: begin tag = "R2"; return color_b; end
         1: begin tag = "R3"; return color_a; end
         2: begin tag = "R4"; return p; end
         default: begin
            if (cursor_mode) begin tag = "R6"; return color_aux; end
            tag = "R5"; return ~p;
         end
      endcase
   endfunction

   task automatic step(bit v, bit s, bit f, logic [23:0] p, logic [23:0] ep, string tag);
      @(negedge clk);
      check_pending();
      in_valid = v; in_sol = s; in_sof = f; in_pix = p;
      pend_have = 1; pend_v = v; pend_sol = s; pend_sof = f; pend_pix = ep; pend_tag = tag;
   endtask

   // R11: positions follow the markers; idle gaps (R9) must not shift them
   task automatic run_frame(int w, int h);
      string tag;
      logic [23:0] p, e;
      for (int y = 0; y < h; y++) begin
         for (int x = 0; x < w; x++) begin
            if ((x + 3*y) % 7 == 3) step(0, 0, 0, 24'hDEAD00 ^ 24'(x), 24'h0, "R9");
            p = {8'(x*5 + y), 8'(y*9), 8'((x ^ y) * 3)};
            e = model(x, y, p, tag);
            step(1, x == 0, (x == 0) && (y == 0), p, e, tag);
         end
      end
      step(0, 0, 0, 24'h0, 24'h0, "R9");   // flush before config changes
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      n_cmp++;   // R12 during reset
      if (out_valid !== 1'b0) begin n_bad++; $display("FAIL R12 out_valid actual=%0b expected=0", out_valid); end
      rst_n = 1'b1;
      @(negedge clk);
      n_cmp++;   // R12 first cycle after reset
      if (out_valid !== 1'b0) begin n_bad++; $display("FAIL R12 out_valid actual=%0b expected=0", out_valid); end

      // R1: load image bytes through the write port
      for (int k = 0; k < 256; k++) begin
         img[k] = 8'((k * 73 + 29) ^ (k >> 3));
         @(negedge clk);
         img_we = 1'b1; img_waddr = 8'(k); img_wdata = img[k];
      end
      @(negedge clk);
      img_we = 1'b0;

      // plain placement, invert treatment
      cursor_en = 1; cursor_mode = 0;
      tip_col = 0; tip_row = 0; tip_col_pos = 10; tip_row_pos = 5;
      run_frame(40, 36);
      // R7 left/top clipping, third colour treatment
      cursor_mode = 1; tip_col = 7; tip_row = 9; tip_col_pos = 3; tip_row_pos = 4;
      run_frame(40, 36);
      // R8 image beyond right and bottom edges
      cursor_mode = 0; tip_col = 2; tip_row = 2; tip_col_pos = 30; tip_row_pos = 20;
      run_frame(40, 36);
      // R7 tip at far corner: only one image pixel on screen
      cursor_mode = 1; tip_col = 31; tip_row = 31; tip_col_pos = 0; tip_row_pos = 0;
      run_frame(40, 36);
      // R10 cursor disabled
      cursor_en = 0; tip_col = 0; tip_row = 0; tip_col_pos = 4; tip_row_pos = 4;
      run_frame(40, 36);
      // short lines, different origin
      cursor_en = 1; cursor_mode = 0; tip_col = 5; tip_row = 3; tip_col_pos = 6; tip_row_pos = 8;
      run_frame(17, 45);

      @(negedge clk);
      check_pending();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule